// File: doc/BRIEF.md
# Ring Signal Qualification Integrator

This block decides whether a genuine ringing signal is present on a telephone line. It receives a single comparator bit that is high while the attenuated line voltage sits above a fixed threshold. On every pulse of an 800 Hz strobe it samples that bit and steps a saturating up/down counter: up when the bit is high, down when it is low. Brief noise spikes cannot qualify a ring. A burst of ringing that is long and dense enough can.

When the count reaches the qualifying level, the active-low ring-detected output goes low. A power controller can use it as a wake-up signal, or a microcontroller as an interrupt. The output returns high as soon as the count drops below that level. The integrator stays idle and empty until an enable input reports that a partial power-up has taken place. The comparator bit is asynchronous to the system clock and passes through a two-flop synchronizer before it is used.

Top module: `ring_qual`

## Requirements
- R1: While rst_ni is low, and immediately after it is released, the count is 0 and ring_det_no is high.
- R2: On a cycle with tick_i high and en_i high, the count rises by one when the synchronized comparator level is 1.
- R3: On a cycle with tick_i high and en_i high, the count falls by one when the synchronized comparator level is 0.
- R4: ring_det_no is low whenever en_i is high and the count is greater than or equal to 48, so a count of exactly 48 asserts it.
- R5: ring_det_no is high whenever the count is below 48.
- R6: The count saturates at 63. Further up-steps leave it at 63 and it never wraps.
- R7: The count saturates at 0. Further down-steps leave it at 0 and it never wraps.
- R8: While en_i is low, ring_det_no is high, the count is cleared to 0, and ticks have no effect.
- R9: On cycles with tick_i low, the count does not change, whatever the comparator does.
- R10: cmp_i passes through two flops before use. A tick in the same cycle as a cmp_i change uses the old level, and a tick two or more cycles after the change uses the new level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Integrator enable, high after partial power-up |
| tick_i | input | 1 | One-cycle 800 Hz sample strobe |
| cmp_i | input | 1 | Asynchronous comparator: ring voltage above threshold |
| ring_det_no | output | 1 | Ring qualified, active low |

## Verification
The bench builds the block with its default parameters: qualifying level 48, ceiling 63, and two synchronizer stages. With a 6-bit count, a sweep can walk the whole range 0..63 in both directions and push past each rail, checking the output after every single step. These values also bring within reach the synchronizer's one-tick lag, the enable clear, and the exact 47/48 boundary approached from both sides.

// File: rtl/ring_qual_pkg.sv
package ring_qual_pkg;
  parameter int unsigned DEF_QUAL_LVL = 48;
  parameter int unsigned DEF_CNT_MAX  = 63;
  parameter int unsigned DEF_SYNC_N   = 2;

  typedef enum logic [1:0] {
    STEP_HOLD = 2'd0,
    STEP_UP   = 2'd1,
    STEP_DOWN = 2'd2
  } step_e;
endpackage

// File: rtl/ring_sync.sv
module ring_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sr_q;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sr_q[i] <= 1'b0;
        else if (i == 0) sr_q[i] <= d_i;
        else sr_q[i] <= sr_q[(i == 0) ? 0 : i-1];
      end
    end
  endgenerate

  assign q_o = sr_q[STAGES-1];
endmodule

// File: rtl/ring_integ.sv
module ring_integ
  import ring_qual_pkg::*;
#(
  parameter int unsigned CNT_MAX = DEF_CNT_MAX,
  localparam int unsigned CNT_W  = $clog2(CNT_MAX + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             tick_i,
  input  logic             lvl_i,
  output logic [CNT_W-1:0] cnt_o
);
  localparam logic [CNT_W-1:0] TOP = CNT_W'(CNT_MAX);

  step_e            step;
  logic [CNT_W-1:0] cnt_q;

  always_comb begin
    if (!tick_i)    step = STEP_HOLD;
    else if (lvl_i) step = STEP_UP;
    else            step = STEP_DOWN;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (!en_i) begin
      cnt_q <= '0;
    end else begin
      unique case (step)
        STEP_UP:   if (cnt_q != TOP) cnt_q <= cnt_q + 1'b1;
        STEP_DOWN: if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
        default:   ;
      endcase
    end
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/ring_qual.sv
module ring_qual
  import ring_qual_pkg::*;
#(
  parameter int unsigned QUAL_LVL = DEF_QUAL_LVL,
  parameter int unsigned CNT_MAX  = DEF_CNT_MAX,
  parameter int unsigned SYNC_N   = DEF_SYNC_N,
  localparam int unsigned CNT_W   = $clog2(CNT_MAX + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic tick_i,
  input  logic cmp_i,
  output logic ring_det_no
);
  logic             cmp_s;
  logic [CNT_W-1:0] cnt_q;

  ring_sync #(.STAGES(SYNC_N)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (cmp_i),
    .q_o   (cmp_s)
  );

  ring_integ #(.CNT_MAX(CNT_MAX)) u_integ (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .en_i  (en_i),
    .tick_i(tick_i),
    .lvl_i (cmp_s),
    .cnt_o (cnt_q)
  );

  // gated by enable so the output drops the same cycle power-up is withdrawn
  assign ring_det_no = !(en_i && (cnt_q >= CNT_W'(QUAL_LVL)));
endmodule

// File: rtl/ring_qual_chk.sv
module ring_qual_chk
  import ring_qual_pkg::*;
#(
  parameter int unsigned QUAL_LVL = DEF_QUAL_LVL,
  parameter int unsigned CNT_MAX  = DEF_CNT_MAX,
  localparam int unsigned CNT_W   = $clog2(CNT_MAX + 1)
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             en_i,
  input logic             tick_i,
  input logic             cmp_s_i,
  input logic [CNT_W-1:0] cnt_i,
  input logic             ring_det_ni
);
  localparam logic [CNT_W-1:0] TOP = CNT_W'(CNT_MAX);
  localparam logic [CNT_W-1:0] LVL = CNT_W'(QUAL_LVL);

  p_inc_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && tick_i && cmp_s_i && cnt_i != TOP) |=> (cnt_i == $past(cnt_i) + 1'b1));

  p_dec_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && tick_i && !cmp_s_i && cnt_i != '0) |=> (cnt_i == $past(cnt_i) - 1'b1));

  p_qual_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && cnt_i >= LVL) |-> !ring_det_ni);

  p_disq_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_i < LVL) |-> ring_det_ni);

  p_no_overflow_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && tick_i && cmp_s_i && cnt_i == TOP) |=> (cnt_i == TOP));

  p_no_underflow_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !cmp_s_i && cnt_i == '0) |=> (cnt_i == '0));

  p_dis_clear_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (cnt_i == '0));

  p_dis_out_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |-> ring_det_ni);

  p_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !tick_i) |=> $stable(cnt_i));
endmodule

bind ring_qual ring_qual_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .en_i       (en_i),
  .tick_i     (tick_i),
  .cmp_s_i    (cmp_s),
  .cnt_i      (cnt_q),
  .ring_det_ni(ring_det_no)
);

// File: tb/ring_qual_test.sv
module ring_qual_test;
  localparam int CLK_P = 10;
  localparam int QUAL  = 48;
  localparam int TOPV  = 63;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic en_i = 1'b0;
  logic tick_i = 1'b0;
  logic cmp_i = 1'b0;
  logic ring_det_no;

  int n_chk = 0;
  int n_bad = 0;
  int model = 0;
  bit model_en = 1'b0;

  always #(CLK_P/2) clk_i = ~clk_i;

  ring_qual uut (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .en_i       (en_i),
    .tick_i     (tick_i),
    .cmp_i      (cmp_i),
    .ring_det_no(ring_det_no)
  );

  function automatic logic exp_out();
    return !(model_en && model >= QUAL);
  endfunction

  task automatic check(input string req);
    logic e;
    e = exp_out();
    n_chk++;
    if (ring_det_no !== e) begin
      n_bad++;
      $display("FAIL %s: ring_det_no=%b expected %b (model count %0d)", req, ring_det_no, e, model);
    end
  endtask

  function automatic void step_model(input bit c);
    if (!model_en) model = 0;
    else if (c && model < TOPV) model++;
    else if (!c && model > 0) model--;
  endfunction

  // settle comparator through the synchronizer, then one tick
  task automatic do_tick(input bit c, input string req);
    @(negedge clk_i) cmp_i = c;
    repeat (2) @(negedge clk_i);
    tick_i = 1'b1;
    @(negedge clk_i) tick_i = 1'b0;
    step_model(c);
    check(req);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk_i);
    n_bad++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin : stim
    // R1 reset state
    repeat (3) @(negedge clk_i);
    check("R1");
    rst_ni = 1'b1;
    @(negedge clk_i);
    check("R1");

    en_i = 1'b1;
    model_en = 1'b1;
    // R2/R4/R6 upward sweep beyond the ceiling
    for (int i = 0; i < 70; i++) do_tick(1'b1, "R2_R4_R6");
    // R3/R5/R7 downward sweep beyond the floor
    for (int i = 0; i < 70; i++) do_tick(1'b0, "R3_R5_R7");
    // R7 floor held: exactly 48 ups to qualify
    for (int i = 0; i < 48; i++) do_tick(1'b1, "R7_R4");

    // R9 no tick: comparator toggles, count stays at 48
    for (int i = 0; i < 40; i++) begin
      @(negedge clk_i) cmp_i = i[0];
    end
    @(negedge clk_i) cmp_i = 1'b0;
    repeat (3) @(negedge clk_i);
    check("R9");
    do_tick(1'b0, "R5");  // 47

    // R10 tick in same cycle as cmp change uses old (low) level
    @(negedge clk_i) begin cmp_i = 1'b1; tick_i = 1'b1; end
    @(negedge clk_i) tick_i = 1'b0;
    step_model(1'b0);     // 46
    check("R10");
    do_tick(1'b1, "R10"); // 47, high
    do_tick(1'b1, "R10"); // 48, low

    // R8 disable forces output high at once
    @(negedge clk_i) begin en_i = 1'b0; model_en = 1'b0; end
    #1 check("R8");
    for (int i = 0; i < 60; i++) do_tick(1'b1, "R8");
    @(negedge clk_i) begin en_i = 1'b1; model_en = 1'b1; end
    // count must restart from 0
    for (int i = 0; i < 48; i++) do_tick(1'b1, "R8");

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule